// File: doc/BRIEF.md
# Hold-Flag Scan Decompressor

This block expands a seed for a linear feedback shift register (LFSR) into stimulus for several scan chains while holding down switching activity during the shift. After a start strobe, one LFSR is loaded with the seed and stepped once per cycle. In its first cycle it yields an update decision. If the decision is set, the next B cycles yield one hold flag per block for every chain. After that the data shift runs for the full chain length.

Each chain is divided into B equal blocks. When the current block's flag for a chain is clear, that chain takes fresh LFSR bits. When the flag is set, the chain input repeats the last bit it was given, so the whole block shifts a constant value. If the update decision is clear, the flags from the previous pattern are reused. The scan chains take `scan_o` while `shift_en_o` is high. `done_o` marks the end of a pattern.

Top module: `hold_scan_decomp`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `shift_en_o`, `done_o` and `scan_o` are 0. All hold flags reset to 0.
- R2: A `start_i` sampled while idle loads `seed_i` into the LFSR. The next cycle is the update cycle: no shifting takes place, and bit 0 of the LFSR state in that cycle is the update flag. The LFSR steps once in that cycle.
- R3: If the update flag is 1, exactly B flag cycles follow with `shift_en_o` low. In flag cycle b (counting from 0), bit c of the LFSR state becomes chain c's hold flag for block b. The LFSR steps once per flag cycle.
- R4: If the update flag is 0, shifting starts in the cycle right after the update cycle and all hold flags keep their previous values.
- R5: The shift phase lasts exactly CHAIN_LEN cycles with `shift_en_o` high. Every cycle the LFSR steps as next = {s[W-2:0], ^(s & TAPS)} (default TAPS 16'hB400, W = 16). Bit c of the state is chain c's fresh bit.
- R6: In shift cycle i, block i / (CHAIN_LEN/B) is the current block. If chain c's flag for that block is 0, `scan_o[c]` equals the fresh bit.
- R7: If chain c's flag for the current block is 1, `scan_o[c]` equals the bit that chain was given in the previous shift cycle. In the first shift cycle of a pattern, that previous bit is 0.
- R8: `done_o` is high for exactly the one cycle after the last shift cycle. The block is idle after that.
- R9: A `start_i` sampled while not idle has no effect on the running pattern.
- R10: `scan_o` is 0 in every cycle where `shift_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a pattern when idle |
| seed_i | input | LFSR_W | Seed captured with start_i |
| scan_o | output | NUM_CHAINS | Scan-in bit per chain |
| shift_en_o | output | 1 | High during the data shift |
| done_o | output | 1 | One-cycle end-of-pattern pulse |

## Verification
A start sampled at edge k makes the update cycle visible after edge k. Any flag cycles are visible from edge k+1 on. The first shift bit follows directly after them, and `done_o` comes one cycle after the last shift. When start is driven, the bench builds the whole expected per-cycle output sequence for that pattern from a behavioural LFSR and flag model and places it in a queue. On each falling edge it pops one entry and compares it with `scan_o`, `shift_en_o` and `done_o`. Cycles with an empty queue are expected to be idle.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_UPD,
    PH_FLAG,
    PH_SHIFT,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/hsd_lfsr.sv
module hsd_lfsr #(
  parameter int unsigned   W    = 16,
  parameter logic [W-1:0]  TAPS = 16'hB400
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '0;
    else if (load_i) s_q <= seed_i;
    else if (adv_i)  s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
  end

  assign state_o = s_q;
endmodule

// File: rtl/hsd_ctrl.sv
module hsd_ctrl
  import hsd_pkg::*;
#(
  parameter int unsigned CHAIN_LEN  = 32,
  parameter int unsigned NUM_BLOCKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic upd_bit_i,
  output logic lfsr_load_o,
  output logic lfsr_adv_o,
  output logic pat_init_o,
  output logic flag_shift_o,
  output logic shift_en_o,
  output logic blk_end_o,
  output logic done_o
);
  localparam int unsigned BLK_LEN = CHAIN_LEN / NUM_BLOCKS;
  localparam int unsigned CNT_W   = $clog2(CHAIN_LEN + 1);
  localparam int unsigned BLK_W   = $clog2(BLK_LEN + 1);

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BLK_W-1:0]  blk_q, blk_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    blk_d = blk_q;
    unique case (ph_q)
      PH_IDLE: if (start_i) ph_d = PH_UPD;
      PH_UPD: begin
        cnt_d = '0;
        blk_d = '0;
        ph_d  = upd_bit_i ? PH_FLAG : PH_SHIFT;
      end
      PH_FLAG: begin
        if (cnt_q == CNT_W'(NUM_BLOCKS - 1)) begin
          cnt_d = '0;
          ph_d  = PH_SHIFT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_SHIFT: begin
        blk_d = blk_end_o ? '0 : blk_q + 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CHAIN_LEN - 1)) ph_d = PH_DONE;
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      blk_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      blk_q <= blk_d;
    end
  end

  assign lfsr_load_o  = (ph_q == PH_IDLE) && start_i;
  assign lfsr_adv_o   = (ph_q == PH_UPD) || (ph_q == PH_FLAG) || (ph_q == PH_SHIFT);
  assign pat_init_o   = (ph_q == PH_UPD);
  assign flag_shift_o = (ph_q == PH_FLAG);
  assign shift_en_o   = (ph_q == PH_SHIFT);
  assign blk_end_o    = shift_en_o && (blk_q == BLK_W'(BLK_LEN - 1));
  assign done_o       = (ph_q == PH_DONE);
endmodule

// File: rtl/hsd_chain.sv
module hsd_chain #(
  parameter int unsigned NUM_BLOCKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fresh_i,
  input  logic pat_init_i,
  input  logic flag_shift_i,
  input  logic shift_en_i,
  input  logic blk_end_i,
  output logic hold_o,
  output logic scan_o
);
  logic [NUM_BLOCKS-1:0] hf_q;
  logic                  held_q;
  logic [NUM_BLOCKS-1:0] hf_in, hf_rot;

  // flag for block 0 ends in bit 0; rotation restores order after B blocks
  assign hf_in  = (hf_q >> 1) | (NUM_BLOCKS'(fresh_i) << (NUM_BLOCKS - 1));
  assign hf_rot = (hf_q >> 1) | (NUM_BLOCKS'(hf_q[0]) << (NUM_BLOCKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hf_q <= '0;
    else if (flag_shift_i)            hf_q <= hf_in;
    else if (shift_en_i && blk_end_i) hf_q <= hf_rot;
  end

  assign hold_o = hf_q[0];
  assign scan_o = hold_o ? held_q : fresh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         held_q <= 1'b0;
    else if (pat_init_i) held_q <= 1'b0;
    else if (shift_en_i) held_q <= scan_o;
  end
endmodule

// File: rtl/hold_scan_decomp.sv
module hold_scan_decomp #(
  parameter int unsigned        NUM_CHAINS = 4,
  parameter int unsigned        CHAIN_LEN  = 32,
  parameter int unsigned        NUM_BLOCKS = 4,
  parameter int unsigned        LFSR_W     = 16,
  parameter logic [LFSR_W-1:0]  LFSR_TAPS  = 16'hB400
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [LFSR_W-1:0]     seed_i,
  output logic [NUM_CHAINS-1:0] scan_o,
  output logic                  shift_en_o,
  output logic                  done_o
);
  logic [LFSR_W-1:0]     lfsr_s;
  logic                  lfsr_load, lfsr_adv, pat_init, flag_shift, blk_end;
  logic [NUM_CHAINS-1:0] hold_sel, chain_bit;

  hsd_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lfsr_load),
    .adv_i   (lfsr_adv),
    .seed_i  (seed_i),
    .state_o (lfsr_s)
  );

  hsd_ctrl #(.CHAIN_LEN(CHAIN_LEN), .NUM_BLOCKS(NUM_BLOCKS)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .upd_bit_i    (lfsr_s[0]),
    .lfsr_load_o  (lfsr_load),
    .lfsr_adv_o   (lfsr_adv),
    .pat_init_o   (pat_init),
    .flag_shift_o (flag_shift),
    .shift_en_o   (shift_en_o),
    .blk_end_o    (blk_end),
    .done_o       (done_o)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    hsd_chain #(.NUM_BLOCKS(NUM_BLOCKS)) i_chain (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .fresh_i      (lfsr_s[c]),
      .pat_init_i   (pat_init),
      .flag_shift_i (flag_shift),
      .shift_en_i   (shift_en_o),
      .blk_end_i    (blk_end),
      .hold_o       (hold_sel[c]),
      .scan_o       (chain_bit[c])
    );
  end

  assign scan_o = shift_en_o ? chain_bit : '0;
endmodule

// File: rtl/hold_scan_decomp_chk.sv
module hold_scan_decomp_chk #(
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CHAIN_LEN  = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_CHAINS-1:0] scan_o,
  input logic                  shift_en_o,
  input logic                  done_o,
  input logic                  flag_shift,
  input logic [NUM_CHAINS-1:0] hold_sel
);
  localparam int unsigned RUN_W = $clog2(CHAIN_LEN + 1) + 1;
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (shift_en_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  a_r5_shift_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_o && $past(shift_en_o)) |-> (run_q == RUN_W'(CHAIN_LEN)));

  a_r8_done_after_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(shift_en_o) && !shift_en_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r3_no_shift_in_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_shift |-> !shift_en_o);

  a_r7_hold_repeats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_o && $past(shift_en_o)) |-> (((scan_o ^ $past(scan_o)) & hold_sel) == '0));

  a_r10_quiet_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |-> (scan_o == '0));
endmodule

bind hold_scan_decomp hold_scan_decomp_chk #(
  .NUM_CHAINS (NUM_CHAINS),
  .CHAIN_LEN  (CHAIN_LEN)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scan_o     (scan_o),
  .shift_en_o (shift_en_o),
  .done_o     (done_o),
  .flag_shift (flag_shift),
  .hold_sel   (hold_sel)
);

// File: tb/test_hold_scan_decomp.sv
module test_hold_scan_decomp;
  localparam int C = 4;
  localparam int L = 32;
  localparam int B = 4;
  localparam int W = 16;
  localparam logic [W-1:0] TAPS = 16'hB400;
  localparam int BL = L / B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] seed = '0;
  logic [C-1:0] scan;
  logic         shift_en, done;

  int checks = 0;
  int errors = 0;

  // expected entry: {shift_en, done, scan}
  logic [C+1:0] exp_q[$];
  bit           flags[C][B];

  always #2.5 clk = ~clk;

  hold_scan_decomp #(
    .NUM_CHAINS(C), .CHAIN_LEN(L), .NUM_BLOCKS(B), .LFSR_W(W), .LFSR_TAPS(TAPS)
  ) i_hold_scan_decomp (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed),
    .scan_o(scan), .shift_en_o(shift_en), .done_o(done)
  );

  function automatic logic [W-1:0] step(logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  // R2..R8: behavioural expansion of one pattern
  task automatic build(logic [W-1:0] sd);
    logic [W-1:0] s = sd;
    bit held[C];
    logic [C-1:0] bits;
    bit upd = s[0];
    for (int c = 0; c < C; c++) held[c] = 1'b0;
    exp_q.push_back('0);
    s = step(s);
    if (upd) begin
      for (int b = 0; b < B; b++) begin
        for (int c = 0; c < C; c++) flags[c][b] = s[c];
        exp_q.push_back('0);
        s = step(s);
      end
    end
    for (int i = 0; i < L; i++) begin
      for (int c = 0; c < C; c++) begin
        bits[c] = flags[c][i / BL] ? held[c] : s[c];
        held[c] = bits[c];
      end
      exp_q.push_back({1'b1, 1'b0, bits});
      s = step(s);
    end
    exp_q.push_back({1'b0, 1'b1, {C{1'b0}}});
  endtask

  task automatic tick();
    logic [C+1:0] e;
    @(negedge clk);
    e = (exp_q.size() != 0) ? exp_q.pop_front() : '0;
    checks++;
    if (shift_en !== e[C+1]) begin
      errors++;
      $display("FAIL R3/R4/R5 shift_en actual=%b expected=%b", shift_en, e[C+1]);
    end
    if (done !== e[C]) begin
      errors++;
      $display("FAIL R8 done actual=%b expected=%b", done, e[C]);
    end
    if (scan !== e[C-1:0]) begin
      errors++;
      $display("FAIL R6/R7/R10 scan actual=%b expected=%b", scan, e[C-1:0]);
    end
  endtask

  task automatic run_pattern(logic [W-1:0] sd, bit poke_busy);
    start = 1'b1;
    seed  = sd;
    build(sd);
    tick();
    start = 1'b0;
    repeat (6) tick();
    if (poke_busy) begin
      // R9: start while busy must leave the queued sequence intact
      start = 1'b1;
      seed  = ~sd;
      tick();
      start = 1'b0;
    end
    while (exp_q.size() != 0) tick();
    if (poke_busy) begin
      start = 1'b1;  // also lands in the done cycle? no: queue drained, block idle
      start = 1'b0;
    end
    tick();
  endtask

  initial begin
    for (int c = 0; c < C; c++)
      for (int b = 0; b < B; b++) flags[c][b] = 1'b0;
    // R1: outputs quiet in reset
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    run_pattern(16'h1234, 1'b0);  // R4 with reset flags
    run_pattern(16'hACE1, 1'b0);  // R3 loads flags
    run_pattern(16'h5A5A, 1'b1);  // R4 keeps flags, R9
    run_pattern(16'hBEEF, 1'b0);  // R3 new flags
    run_pattern(16'h7777, 1'b1);
    run_pattern(16'h0F0E, 1'b0);
    run_pattern(16'hC3A5, 1'b0);
    repeat (4) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule